// File: doc/BRIEF.md
# Half-Warp Memory Request Coalescer

This block takes one memory request issued together by a group of 16 lanes and turns it into the shortest list of memory transactions that serves every active lane. Each lane gives an active flag and a byte address. One access width (32, 64 or 128 bits) applies to the whole group. A mode input picks a strict rule set or a relaxed one. Transactions leave one per cycle over a valid/ready handshake. Each transaction carries an aligned base address and a size in bytes.

In strict mode the request coalesces only if each active lane k addresses word k of one aligned block. The block is 16 words long: 64 bytes for 32-bit words, 128 bytes for 64-bit words, and two consecutive 128-byte segments for 128-bit words. Any violation makes the block serve each active lane with its own transaction. In relaxed mode the lanes may address words in any order. The block issues one transaction per 128-byte region touched, and shrinks each one to the smallest aligned 32, 64 or 128-byte segment that covers the bytes used. When a request finishes, a one-cycle pulse reports how many transactions it needed.

Top module: `hw_coalescer`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_base`, `tx_bytes` and `tx_last` hold their values.
- R2: Strict mode, size code 0 (32-bit words): if every active lane k addresses byte `S + 4k`, where S is 64-byte aligned, then exactly one transaction is issued, with base S and 64 bytes.
- R3: Strict mode, size code 1 (64-bit words): if every active lane k addresses byte `S + 8k`, where S is 128-byte aligned, then exactly one transaction is issued, with base S and 128 bytes.
- R4: Strict mode, size code 2 or 3 (128-bit words): if every active lane k addresses byte `S + 16k`, where S is 256-byte aligned, then exactly two transactions are issued: base S, then base S+128, each of 128 bytes.
- R5: In strict mode, inactive lanes have no effect on whether a request coalesces. Their addresses are ignored.
- R6: A strict request that breaks R2–R4 issues one transaction per active lane. Each has the word-aligned lane address as its base and the word size as its byte count. Lanes with equal addresses are served in ascending lane order.
- R7: In relaxed mode, exactly one transaction is issued for each distinct 128-byte aligned region touched by an active lane. The order of addresses within a region does not matter.
- R8: In relaxed mode, each transaction's size is the smallest of 32, 64 or 128 bytes whose aligned segment covers every byte the active lanes use in that region. Its base is that segment's aligned start.
- R9: The transactions of a request are issued in ascending order of base address. `tx_last` is high only on the final one.
- R10: `done` pulses for one cycle after the last transaction is accepted, and `done_count` gives the number of transactions. A request with no active lanes produces `done` with count 0 on the cycle after acceptance and issues no transaction.
- R11: Address bits below the word size are ignored. Each lane address is first rounded down to a word boundary.
- R12: After reset, `req_ready` is high and `tx_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_active | input | LANES | Per-lane active flags |
| req_addr | input | LANES*AW | Lane byte addresses, lane k at bits k*AW upward |
| req_size | input | 2 | Word size: 0=32 bit, 1=64 bit, 2 or 3=128 bit |
| req_relaxed | input | 1 | 1 selects the relaxed rule set |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Downstream accepts the transaction |
| tx_base | output | AW | Aligned transaction base address |
| tx_bytes | output | 8 | Transaction size in bytes |
| tx_last | output | 1 | Final transaction of the request |
| done | output | 1 | One-cycle pulse when a request completes |
| done_count | output | CW | Transactions used by the completed request |

## Verification
Two situations are the hardest to reach from the ports. The first is a strict request that fails by only one subtle detail: two lanes swapped, a segment start aligned one level too fine, or duplicate addresses that must keep lane order. The second is a relaxed request whose byte span straddles a 32- or 64-byte boundary inside one region. Directed vectors build each of these address patterns exactly, and sparse active masks show that disabled lanes with wild addresses are ignored. Random requests then draw lane addresses from only four adjacent regions, so collisions, duplicates and multi-region lists occur often. These random requests run under random and delayed `tx_ready`, which exercises holding a transaction while downstream stalls.

// File: rtl/hw_coalescer.sv
module hw_coalescer #(
  parameter int LANES = 16,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [LANES-1:0]     req_active,
  input  logic [LANES*AW-1:0]  req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_relaxed,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [AW-1:0]        tx_base,
  output logic [7:0]           tx_bytes,
  output logic                 tx_last,
  output logic                 done,
  output logic [$clog2(LANES+1)-1:0] done_count
);
  localparam int CW = $clog2(LANES + 1);
  localparam int IW = $clog2(LANES);
  localparam int RB = 7;

  typedef enum logic [1:0] {K_ONE, K_LANE, K_SEG} kind_t;

  logic             busy, phase;
  kind_t            kind;
  logic [1:0]       szr;
  logic [LANES-1:0] pend, grp;
  logic [AW-1:0]    ar [LANES];
  logic [AW-1:0]    sbase;
  logic [CW-1:0]    cnt;

  logic [1:0]    in_sz;
  logic [2:0]    in_sh, sh;
  logic [AW-1:0] in_wa [LANES];
  logic [AW-1:0] in_ref;
  logic          in_ok;

  assign in_sz = (req_size == 2'd3) ? 2'd2 : req_size;
  assign in_sh = {1'b0, in_sz} + 3'd2;
  assign sh    = {1'b0, szr} + 3'd2;

  always_comb begin
    logic seen;
    logic [AW-1:0] n;
    seen = 1'b0;
    in_ok = 1'b1;
    in_ref = '0;
    for (int k = 0; k < LANES; k++) begin
      in_wa[k] = req_addr[k*AW +: AW] & ~((AW'(1) << in_sh) - AW'(1));
      n = in_wa[k] - (AW'(k) << in_sh);
      if (req_active[k]) begin
        if (!seen) in_ref = n;
        else if (n != in_ref) in_ok = 1'b0;
        seen = 1'b1;
      end
    end
    if ((in_ref & ((AW'(LANES) << in_sh) - AW'(1))) != '0) in_ok = 1'b0;
  end

  logic [IW-1:0] sel;
  logic [RB-1:0] lo, hi;
  logic [AW-1:0] seg_base;
  logic [7:0]    seg_bytes;

  always_comb begin
    logic found;
    logic [RB-1:0] off, fin, msk;
    found = 1'b0;
    sel = '0;
    for (int k = 0; k < LANES; k++)
      if (pend[k] && (!found || ar[k] < ar[sel])) begin
        sel = IW'(k);
        found = 1'b1;
      end
    for (int k = 0; k < LANES; k++)
      case (kind)
        K_SEG:   grp[k] = pend[k] && (ar[k][AW-1:RB] == ar[sel][AW-1:RB]);
        K_LANE:  grp[k] = pend[k] && (IW'(k) == sel);
        default: grp[k] = pend[k];
      endcase
    lo = '1;
    hi = '0;
    for (int k = 0; k < LANES; k++)
      if (grp[k]) begin
        off = ar[k][RB-1:0];
        fin = off + ((RB'(1) << sh) - RB'(1));
        if (off < lo) lo = off;
        if (fin > hi) hi = fin;
      end
    if (lo[RB-1:5] == hi[RB-1:5]) begin
      seg_bytes = 8'd32;
      msk = RB'(31);
    end else if (lo[RB-1] == hi[RB-1]) begin
      seg_bytes = 8'd64;
      msk = RB'(63);
    end else begin
      seg_bytes = 8'd128;
      msk = RB'(127);
    end
    seg_base = {ar[sel][AW-1:RB], lo & ~msk};
  end

  always_comb begin
    case (kind)
      K_SEG: begin
        tx_base  = seg_base;
        tx_bytes = seg_bytes;
        tx_last  = (pend & ~grp) == '0;
      end
      K_LANE: begin
        tx_base  = ar[sel];
        tx_bytes = 8'd1 << sh;
        tx_last  = (pend & ~grp) == '0;
      end
      default: begin
        tx_base  = sbase + (phase ? AW'(128) : AW'(0));
        tx_bytes = (szr == 2'd2) ? 8'd128 : (8'(LANES) << sh);
        tx_last  = (szr != 2'd2) || phase;
      end
    endcase
  end

  assign req_ready = !busy;
  assign tx_valid  = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      phase <= 1'b0;
      kind <= K_ONE;
      szr <= '0;
      pend <= '0;
      sbase <= '0;
      cnt <= '0;
      done <= 1'b0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && req_valid) begin
        if (req_active == '0) begin
          done <= 1'b1;
          done_count <= '0;
        end else begin
          busy <= 1'b1;
          pend <= req_active;
          szr <= in_sz;
          kind <= req_relaxed ? K_SEG : (in_ok ? K_ONE : K_LANE);
          sbase <= in_ref;
          phase <= 1'b0;
          cnt <= '0;
        end
      end else if (busy && tx_ready) begin
        cnt <= cnt + CW'(1);
        pend <= pend & ~grp;
        phase <= 1'b1;
        if (tx_last) begin
          busy <= 1'b0;
          done <= 1'b1;
          done_count <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (!busy && req_valid)
      for (int k = 0; k < LANES; k++) ar[k] <= in_wa[k];

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) && $stable(tx_bytes) && $stable(tx_last));
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(req_valid));
  p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_base & AW'(tx_bytes - 8'd1)) == '0);
  p_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $countones(tx_bytes) == 1);
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid && done_count <= CW'(LANES));
  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> done);
endmodule

// File: tb/tb_hw_coalescer.sv
module tb_hw_coalescer;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_relaxed = 0;
  logic [15:0] req_active = '0;
  logic [511:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic tx_valid, tx_ready = 1, tx_last, done;
  logic [31:0] tx_base;
  logic [7:0] tx_bytes;
  logic [4:0] done_count;

  hw_coalescer dut (.*);

  always #2 clk = ~clk;

  int vectors = 0, fails = 0;
  string cur = "R12";
  logic [31:0] a [16];
  logic [31:0] qb [$];
  int qs [$];
  bit busy_m = 0, done_m = 0;
  int total = 0, dcnt_m = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic build();
    int w, sz;
    int unsigned wa [16];
    bit used [16];
    sz = (req_size == 3) ? 2 : req_size;
    w = 4 << sz;
    for (int k = 0; k < 16; k++) begin
      wa[k] = a[k] & ~(w - 1);
      used[k] = !req_active[k];
    end
    if (req_active == 0) return;
    if (!req_relaxed) begin
      bit ok;
      int k0;
      int unsigned base;
      ok = 1; k0 = -1;
      for (int k = 0; k < 16; k++) if (req_active[k] && k0 < 0) k0 = k;
      base = wa[k0] - k0 * w;
      if (base % (16 * w) != 0) ok = 0;
      for (int k = 0; k < 16; k++) if (req_active[k] && wa[k] != base + k * w) ok = 0;
      if (ok) begin
        if (w == 16) begin
          qb.push_back(base); qs.push_back(128);
          qb.push_back(base + 128); qs.push_back(128);
        end else begin
          qb.push_back(base); qs.push_back(16 * w);
        end
        return;
      end
      for (int it = 0; it < 16; it++) begin
        int best;
        best = -1;
        for (int k = 0; k < 16; k++)
          if (!used[k] && (best < 0 || wa[k] < wa[best])) best = k;
        if (best >= 0) begin
          used[best] = 1;
          qb.push_back(wa[best]); qs.push_back(w);
        end
      end
    end else begin
      for (int it = 0; it < 16; it++) begin
        int best, lo, hi, seg;
        int unsigned r;
        best = -1;
        for (int k = 0; k < 16; k++)
          if (!used[k] && (best < 0 || (wa[k] >> 7) < (wa[best] >> 7))) best = k;
        if (best >= 0) begin
          r = wa[best] >> 7;
          lo = 127; hi = 0;
          for (int k = 0; k < 16; k++)
            if (!used[k] && (wa[k] >> 7) == r) begin
              used[k] = 1;
              if ((wa[k] & 127) < lo) lo = wa[k] & 127;
              if ((wa[k] & 127) + w - 1 > hi) hi = (wa[k] & 127) + w - 1;
            end
          seg = 32;
          while (lo / seg != hi / seg) seg = seg * 2;
          qb.push_back((r << 7) + (lo / seg) * seg); qs.push_back(seg);
        end
      end
    end
  endtask

  task automatic step();
    bit dn;
    dn = 0;
    if (busy_m) begin
      if (tx_ready) begin
        void'(qb.pop_front()); void'(qs.pop_front());
        total++;
        if (qb.size() == 0) begin busy_m = 0; dn = 1; dcnt_m = total; end
      end
    end else if (req_valid) begin
      qb.delete(); qs.delete();
      build();
      total = 0;
      if (qb.size() == 0) begin dn = 1; dcnt_m = 0; end
      else busy_m = 1;
    end
    done_m = dn;
    @(negedge clk);
    chk("R1 req_ready", req_ready, !busy_m);
    chk({cur, " tx_valid"}, tx_valid, busy_m);
    if (busy_m && tx_valid) begin
      chk({cur, " R9 tx_base"}, tx_base, qb[0]);
      chk({cur, " tx_bytes"}, tx_bytes, qs[0]);
      chk({cur, " R9 tx_last"}, tx_last, qb.size() == 1);
    end
    chk("R10 done", done, done_m);
    if (done_m) chk({cur, " R10 done_count"}, done_count, dcnt_m);
  endtask

  task automatic send(input logic [15:0] act, input bit rel, input logic [1:0] sz,
                      input int rmode, input string tag);
    int n;
    cur = tag;
    for (int k = 0; k < 16; k++) req_addr[k*32 +: 32] = a[k];
    req_active = act; req_relaxed = rel; req_size = sz;
    req_valid = 1; tx_ready = 1;
    step();
    req_valid = 0;
    n = 0;
    while (busy_m) begin
      case (rmode)
        1: tx_ready = $urandom % 2;
        2: tx_ready = (n >= 3);
        default: tx_ready = 1;
      endcase
      step();
      n++;
    end
    tx_ready = 1;
    step();
  endtask

  task automatic contig(input logic [31:0] base, input int w);
    for (int k = 0; k < 16; k++) a[k] = base + k * w;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 req_ready", req_ready, 1);
    chk("R12 tx_valid", tx_valid, 0);
    chk("R12 done", done, 0);

    contig(32'h1000, 4);  send(16'hFFFF, 0, 0, 0, "R2");
    contig(32'h2080, 8);  send(16'hFFFF, 0, 1, 2, "R3");
    contig(32'h3000, 16); send(16'hFFFF, 0, 2, 1, "R4");
    contig(32'h3100, 16); send(16'hFFFF, 0, 3, 0, "R4");
    contig(32'h1000, 4);
    a[0] = 32'hDEAD0000; a[2] = 32'h7; a[5] = 32'h12345678;
    send(16'hFFDA, 0, 0, 0, "R5");
    contig(32'h1001, 4); a[3] = 32'h100F;
    send(16'hFFFF, 0, 0, 0, "R11");
    contig(32'h1000, 4); a[0] = 32'h1004; a[1] = 32'h1000;
    send(16'hFFFF, 0, 0, 2, "R6");
    contig(32'h1020, 4);  send(16'hFFFF, 0, 0, 0, "R6");
    contig(32'h5000, 8); a[4] = 32'h5000; a[9] = 32'h5000;
    send(16'hFFFF, 0, 1, 1, "R6");
    contig(32'h1000, 4); a[0] = 32'h1004; a[1] = 32'h1000;
    send(16'hFFFF, 1, 0, 0, "R7");
    for (int k = 0; k < 16; k++) a[k] = 32'h4040 + ((k * 7) % 8) * 4;
    send(16'hFFFF, 1, 0, 0, "R8");
    for (int k = 0; k < 16; k++) a[k] = 32'h4030 + (k % 7) * 4;
    send(16'hFFFF, 1, 0, 0, "R8");
    for (int k = 0; k < 16; k++) a[k] = 32'h4020 + (k % 8) * 4;
    send(16'hFFFF, 1, 0, 0, "R8");
    for (int k = 0; k < 16; k++)
      a[k] = (k % 3 == 0) ? 32'h9010 : (k % 3 == 1) ? 32'h4070 : 32'h5000 + k * 4;
    send(16'hFFFF, 1, 0, 1, "R9");
    contig(32'h1000, 4); send(16'h0000, 0, 0, 0, "R10");
    send(16'h0000, 1, 2, 0, "R10");

    for (int i = 0; i < 60; i++) begin
      logic [1:0] sz;
      sz = $urandom % 4;
      if (i % 3 == 0) contig(32'h8000 + (($urandom % 4) << 8), 4 << ((sz == 3) ? 2 : sz));
      else for (int k = 0; k < 16; k++) a[k] = 32'h8000 + (($urandom % 4) << 7) + ($urandom % 128);
      send((i % 5 == 0) ? 16'hFFFF : 16'($urandom), $urandom % 2, sz, i % 3, (i % 2) ? "R7" : "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule